// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block derives a slow square wave from the bus clock and presents it as an output value together with an output-enable. Software configures it through one 8-bit control register. The register holds a 3-bit divide code and an enable bit. For a nonzero code N, the output runs at the bus clock frequency divided by 2·N. Each high and each low phase lasts N bus clocks, so the duty cycle is 50%.

The register sits behind a single register select. A write takes effect at the clock edge on which both the select and the write strobe are high. Read data is combinational and reflects the stored fields while the select is high.

A code of zero with the enable set holds the output low. Clearing the enable deasserts the output-enable and forces the output value to 0. A write that changes the divide code restarts the waveform from its low phase. A write that keeps the code and the enable leaves the running phase untouched. Pin multiplexing is outside this block: the surrounding port logic consumes the value and enable pins directly.

Top module: `clkout_divider`

## Requirements
- R1: After reset the register reads 0x00, `clk_out` is 0 and `clk_out_en` is 0.
- R2: With `reg_sel` high, `rd_data` returns the enable in bit 4 and the divide code in bits 2:0, with all other bits 0. With `reg_sel` low, `rd_data` is 0x00.
- R3: A write (`reg_sel` and `wr_en` high at a rising edge) stores bit 4 and bits 2:0 of `wr_data` at that edge. Bits 7:5 and bit 3 of the data are discarded and always read back as 0.
- R4: When `reg_sel` is low at an edge, `wr_en` has no effect on the stored register.
- R5: While the enable bit is 0, `clk_out_en` is 0 and `clk_out` is 0.
- R6: While the enable bit is 1, `clk_out_en` is 1.
- R7: With the enable set and a nonzero code N, `clk_out` is 0 from the write edge onward, first rises N edges after that write edge, and then toggles every N edges.
- R8: With the enable set and a code of 0, `clk_out` stays 0.
- R9: A write whose code differs from the stored code forces `clk_out` to 0 at that edge and restarts the R7 timing with the new code.
- R10: A write that keeps the stored code with the enable set does not disturb the phase of `clk_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Selects the control register for read and write |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| clk_out | output | 1 | Divided clock value |
| clk_out_en | output | 1 | Output enable for the pin driver |

## Verification
The waveform is checked edge by edge against a bench function of the cycles elapsed since the configuring write. The directed codes are 1, 3, 5 and 7. Code 1 catches an off-by-one in the terminal count, since each phase then lasts a single clock. Code 7 exercises the full counter width. Random register bytes with garbage in the unimplemented bits test field isolation and readback. The directed sequences tell apart three cases: a rewrite with the same code (phase must continue), a rewrite with a new code (phase must restart), and a zero code or cleared enable (output must be held low).

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CTRL_W   = 8;
  localparam int CODE_W   = 3;
  localparam int ENA_POS  = 4;
endpackage

// File: rtl/clkdiv_ctrl_reg.sv
module clkdiv_ctrl_reg #(
  parameter int REG_W   = clkdiv_pkg::CTRL_W,
  parameter int CODE_W  = clkdiv_pkg::CODE_W,
  parameter int ENA_POS = clkdiv_pkg::ENA_POS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              ena_o,
  output logic [CODE_W-1:0] code_o,
  output logic              restart_o
);
  logic              ena_q;
  logic [CODE_W-1:0] code_q;
  logic              wr_hit;
  logic [CODE_W-1:0] new_code;
  logic              new_ena;
  logic              unused_wr_bits;

  assign wr_hit         = reg_sel & wr_en;
  assign new_code       = wr_data[CODE_W-1:0];
  assign new_ena        = wr_data[ENA_POS];
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q  <= 1'b0;
      code_q <= '0;
    end else if (wr_hit) begin
      ena_q  <= new_ena;
      code_q <= new_code;
    end
  end

  // Restart the divider on a code change or when the output is being turned off.
  assign restart_o = wr_hit & ((new_code != code_q) | ~new_ena);

  always_comb begin
    rd_data = '0;
    if (reg_sel) begin
      rd_data[ENA_POS]       = ena_q;
      rd_data[CODE_W-1:0]    = code_q;
    end
  end

  assign ena_o  = ena_q;
  assign code_o = code_q;

  assert_wr_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (ena_q == $past(new_ena)) && (code_q == $past(new_code)));

  assert_unselected_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |=> $stable(ena_q) && $stable(code_q));
endmodule

// File: rtl/clkdiv_toggle.sv
module clkdiv_toggle #(
  parameter int CODE_W = clkdiv_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ena,
  input  logic [CODE_W-1:0] code,
  input  logic              clear,
  output logic              out_o
);
  logic [CODE_W-1:0] cnt_q;
  logic [CODE_W-1:0] last_cnt;
  logic              out_q;

  assign last_cnt = code - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (clear || !ena || (code == '0)) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (cnt_q == last_cnt) begin
      cnt_q <= '0;
      out_q <= ~out_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign out_o = out_q;

  assert_off_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ena |-> !out_q);

  assert_zero_code_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ena && (code == '0)) |-> !out_q);

  assert_rise_on_terminal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q && !$past(out_q)) |-> ((($past(cnt_q) + 1'b1) == $past(code)) && !$past(clear)));
endmodule

// File: rtl/clkout_divider.sv
module clkout_divider #(
  parameter int REG_W   = clkdiv_pkg::CTRL_W,
  parameter int CODE_W  = clkdiv_pkg::CODE_W,
  parameter int ENA_POS = clkdiv_pkg::ENA_POS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             clk_out,
  output logic             clk_out_en
);
  logic              ena_w;
  logic [CODE_W-1:0] code_w;
  logic              restart_w;

  clkdiv_ctrl_reg #(.REG_W(REG_W), .CODE_W(CODE_W), .ENA_POS(ENA_POS)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .ena_o     (ena_w),
    .code_o    (code_w),
    .restart_o (restart_w)
  );

  clkdiv_toggle #(.CODE_W(CODE_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .ena   (ena_w),
    .code  (code_w),
    .clear (restart_w),
    .out_o (clk_out)
  );

  assign clk_out_en = ena_w;

  assert_code_change_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && wr_en && (wr_data[CODE_W-1:0] != code_w)) |=> !clk_out);
endmodule

// File: tb/clkout_divider_test.sv
`timescale 1ns/1ps
module clkout_divider_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       clk_out;
  logic       clk_out_en;

  int  checks = 0;
  int  fails = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  clkout_divider uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .clk_out(clk_out), .clk_out_en(clk_out_en)
  );

  function automatic logic exp_wave(int k, int n);
    return ((k / n) % 2) == 1;
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] d);
    return d & 8'h17;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_write(logic [7:0] d, logic sel = 1'b1);
    @(negedge clk);
    reg_sel = sel; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; reg_sel = 1'b0; wr_data = 8'h00;
  endtask

  task automatic read_reg(output logic [7:0] v);
    reg_sel = 1'b1;
    #1;
    v = rd_data;
    reg_sel = 1'b0;
  endtask

  // Sampling point k is the falling edge after the k-th rising edge since the write edge.
  task automatic watch(int n, int from, int upto, string req);
    for (int k = from; k <= upto; k++) begin
      if (k != from) @(negedge clk);
      check(clk_out === exp_wave(k, n), req, int'(clk_out), int'(exp_wave(k, n)));
    end
  endtask

  task automatic watch_low(int cycles, string req);
    for (int k = 0; k < cycles; k++) begin
      if (k != 0) @(negedge clk);
      check(clk_out === 1'b0, req, int'(clk_out), 0);
    end
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] d;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    read_reg(v);
    check(v == 8'h00, "R1 read", v, 0);
    check(clk_out === 1'b0, "R1 clk_out", int'(clk_out), 0);
    check(clk_out_en === 1'b0, "R1 clk_out_en", int'(clk_out_en), 0);

    // R7 code 3
    do_write(8'h13);
    read_reg(v);
    check(v == 8'h13, "R2 readback", v, 8'h13);
    check(clk_out_en === 1'b1, "R6 enable", int'(clk_out_en), 1);
    watch(3, 0, 12, "R7 code3");

    // R10 same code rewrite, garbage in unimplemented bits; write edge is k=14
    do_write(8'hF3);
    watch(3, 14, 22, "R10 phase kept");
    read_reg(v);
    check(v == 8'h13, "R3 unimplemented bits", v, 8'h13);

    // R9 code change restarts
    do_write(8'h15);
    watch(5, 0, 14, "R9 restart code5");

    // R8 zero code with enable
    do_write(8'h10);
    check(clk_out_en === 1'b1, "R6 enable code0", int'(clk_out_en), 1);
    watch_low(10, "R8 zero code");

    // R4 write without select
    do_write(8'h12, 1'b0);
    read_reg(v);
    check(v == 8'h10, "R4 unselected write", v, 8'h10);

    // R2 read without select
    #1;
    check(rd_data == 8'h00, "R2 unselected read", rd_data, 0);

    // R5 disabled with nonzero code
    do_write(8'h07);
    check(clk_out_en === 1'b0, "R5 enable off", int'(clk_out_en), 0);
    watch_low(12, "R5 output low");

    // R7 extremes: code 1 and code 7
    do_write(8'h11);
    watch(1, 0, 6, "R7 code1");
    do_write(8'h17);
    watch(7, 0, 30, "R7 code7");

    // Random configurations
    for (int it = 0; it < 25; it++) begin
      do_write(8'h00);
      d = 8'($urandom);
      do_write(d);
      read_reg(v);
      check(v == exp_read(d), "R3 random readback", v, exp_read(d));
      check(clk_out_en === d[4], d[4] ? "R6 random enable" : "R5 random enable",
            int'(clk_out_en), int'(d[4]));
      if (d[4] && (d[2:0] != 3'd0))
        watch(int'(d[2:0]), 0, 2 * int'(d[2:0]) + 3, "R7 random wave");
      else
        watch_low(6, d[4] ? "R8 random low" : "R5 random low");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule